// File: doc/BRIEF.md
# I2C Controller Control and Clock-Timing Registers

This block is the register file that sits between a host bus and an I2C protocol engine. Software never writes the control byte directly. One write-only address sets the control bits that are written as one. A second write-only address clears the control bits that are written as one. In both cases a written zero leaves the bit as it was. The control byte holds five live bits: interface enable, START request, STOP request, interrupt flag and acknowledge enable. Each bit drives the engine directly.

The engine talks back through two single-cycle strobes. An event strobe raises the interrupt flag. A stop-complete strobe drops the STOP request. The block also holds two clock-timing registers, one for the SCL high time and one for the SCL low time. Both are read/write, and together they set the master SCL frequency. When software turns the interface off, STOP is forced low, and a one-cycle pulse tells the engine to discard its bus status and return to the idle, not-addressed slave state.

When the engine sees START set, it enters master mode and issues a START condition. If it is already master, it issues a repeated START instead.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After a synchronous reset, all control bits are zero, both timing registers hold 4 and the bus-reset pulse is low.
- R2: A write to address 1 (set port) sets each control bit whose written data bit is one. Bits written as zero keep their value.
- R3: A write to address 2 (clear port) clears each control bit whose written data bit is one. Bits written as zero keep their value.
- R4: Control bits 0, 1 and 7 always read as zero, and writes to them are discarded. Reads of addresses 1, 2 and 5 to 7 return zero. Writes to addresses 0 and 5 to 7 change nothing.
- R5: STOP (bit 4) is zero whenever enable (bit 6) is zero. This holds even when a set-port write asks for STOP without enable, and when enable is cleared while STOP is set.
- R6: An engine interrupt strobe sets the interrupt flag (bit 3) at the next edge. If a clear-port write to bit 3 arrives in the same cycle, the strobe wins.
- R7: An engine stop-complete strobe clears STOP at the next edge. If a set-port write of bit 4 arrives in the same cycle, the write wins.
- R8: When enable falls from one to zero, the bus-reset output is high for exactly the first cycle in which enable reads zero. At no other time is it high.
- R9: Address 3 holds the SCL high time and address 4 holds the SCL low time. Each is written and read back at full width and is driven on its own output.
- R10: Address 0 reads the control byte with enable on bit 6, START on bit 5, STOP on bit 4, interrupt on bit 3 and acknowledge on bit 2. The five control outputs follow these bits, with each change visible in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe for the addressed register |
| host_addr | input | 3 | Register address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data for host_addr (combinational) |
| eng_evt_irq | input | 1 | Engine event strobe that sets the interrupt flag |
| eng_stop_done | input | 1 | Engine strobe that clears the STOP request |
| ctl_enable | output | 1 | Interface enable |
| ctl_start | output | 1 | START / repeated START request |
| ctl_stop | output | 1 | STOP request |
| ctl_irq | output | 1 | Interrupt flag |
| ctl_ack | output | 1 | Acknowledge enable |
| scl_high_cnt | output | TIME_W | SCL high time |
| scl_low_cnt | output | TIME_W | SCL low time |
| eng_bus_reset | output | 1 | One-cycle pulse on an enable falling edge |

## Verification
The control byte is first driven by directed patterns. These include an all-ones set-port write, which separates the live bits from the reserved ones. An enable clear while STOP is set shows both the forced STOP drop and the bus-reset pulse. Collision cycles put an engine strobe against a write in the same cycle, and they show which source has priority on the interrupt and STOP bits. After that, a long seeded random mix runs: writes spread over all eight addresses with random data, plus sparse engine strobes. A reference model in the bench predicts every output and every read. This random mix reaches ordering effects, such as a set and a clear of the same bit over nearby cycles, that the directed cases do not try.

// File: rtl/i2c_ctrl_pkg.sv
// Shared definitions for the I2C control register block: register
// addresses and the bit positions the protocol engine decodes.
package i2c_ctrl_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTL  = 3'd0,
        ADR_SET  = 3'd1,
        ADR_CLR  = 3'd2,
        ADR_SCLH = 3'd3,
        ADR_SCLL = 3'd4
    } reg_addr_e;

    localparam int BIT_ACK = 2;
    localparam int BIT_IRQ = 3;
    localparam int BIT_STO = 4;
    localparam int BIT_STA = 5;
    localparam int BIT_EN  = 6;

    localparam logic [7:0] CTL_LIVE = 8'h7C;
endpackage

// File: rtl/i2c_ctl_byte.sv
// Control byte with set-on-one / clear-on-one update.
// Assumes: at most one of set_we / clr_we is high per cycle (one host bus).
// Applies engine strobes and the enable-gates-STOP rule, and produces a
// one-cycle bus-reset pulse when enable falls.
module i2c_ctl_byte
    import i2c_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_we,
    input  logic       clr_we,
    input  logic [7:0] wbits,
    input  logic       evt_irq,
    input  logic       evt_stop_done,
    output logic [7:0] ctl_q,
    output logic       bus_rst
);
    logic [7:0] set_mask;
    logic [7:0] clr_mask;
    logic [7:0] ctl_d;

    // Next control byte: host set/clear, engine strobes, then the STOP gate.
    always_comb begin
        set_mask = set_we ? (wbits & CTL_LIVE) : 8'h00;
        clr_mask = clr_we ? (wbits & CTL_LIVE) : 8'h00;
        ctl_d    = (ctl_q | set_mask) & ~clr_mask;
        if (evt_irq)
            ctl_d[BIT_IRQ] = 1'b1;
        if (evt_stop_done && !set_mask[BIT_STO])
            ctl_d[BIT_STO] = 1'b0;
        if (!ctl_d[BIT_EN])
            ctl_d[BIT_STO] = 1'b0;
    end

    // Control register and enable-fall pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= 8'h00;
            bus_rst <= 1'b0;
        end else begin
            ctl_q   <= ctl_d;
            bus_rst <= ctl_q[BIT_EN] & ~ctl_d[BIT_EN];
        end
    end

    AST_STO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[BIT_EN] |-> !ctl_q[BIT_STO]); // R5
    AST_IRQ_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> ctl_q[BIT_IRQ]); // R6
    AST_STOP_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stop_done && !(set_we && wbits[BIT_STO])) |=> !ctl_q[BIT_STO]); // R7
    AST_BUS_RST_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q[BIT_EN]) |-> bus_rst); // R8
    AST_BUS_RST_ONLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |-> (!ctl_q[BIT_EN] && $past(ctl_q[BIT_EN]))); // R8
    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q & ~CTL_LIVE) == 8'h00); // R4
endmodule

// File: rtl/i2c_scl_time_reg.sv
// One SCL timing register: full-width write, reset to a parameter value.
// Assumes: the write strobe is already decoded for this register's address.
module i2c_scl_time_reg #(
    parameter int          WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = WIDTH'(4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);
    // Timing value storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (we)
            q <= wdata;
    end

    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(we) |-> $stable(q)); // R9
endmodule

// File: rtl/i2c_rd_mux.sv
// Read-data selection: the control byte, the two timing registers, and zero
// for the write-only and unmapped addresses.
// Assumes: TIME_W <= DATA_W and DATA_W >= 8.
module i2c_rd_mux
    import i2c_ctrl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TIME_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        ctl,
    input  logic [TIME_W-1:0] scl_hi,
    input  logic [TIME_W-1:0] scl_lo,
    output logic [DATA_W-1:0] rdata
);
    // Address decode for reads.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTL:  rdata[7:0]        = ctl;
            ADR_SCLH: rdata[TIME_W-1:0] = scl_hi;
            ADR_SCLL: rdata[TIME_W-1:0] = scl_lo;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_ctrl_regs.sv
// Host-facing control register block of an I2C controller.
// Assumes: a single-cycle host write strobe and a combinational read path;
// engine strobes are single-cycle and synchronous to clk.
module i2c_ctrl_regs
    import i2c_ctrl_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int TIME_W   = 16,
    parameter int TIME_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_evt_irq,
    input  logic              eng_stop_done,
    output logic              ctl_enable,
    output logic              ctl_start,
    output logic              ctl_stop,
    output logic              ctl_irq,
    output logic              ctl_ack,
    output logic [TIME_W-1:0] scl_high_cnt,
    output logic [TIME_W-1:0] scl_low_cnt,
    output logic              eng_bus_reset
);
    localparam int N_TIME = 2;

    logic [7:0]        ctl_q;
    logic              set_we;
    logic              clr_we;
    logic [TIME_W-1:0] time_q  [N_TIME];
    logic              time_we [N_TIME];

    // Write decode for the two control ports.
    always_comb begin
        set_we = host_wr && (host_addr == ADR_SET);
        clr_we = host_wr && (host_addr == ADR_CLR);
    end

    i2c_ctl_byte u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_we        (set_we),
        .clr_we        (clr_we),
        .wbits         (host_wdata[7:0]),
        .evt_irq       (eng_evt_irq),
        .evt_stop_done (eng_stop_done),
        .ctl_q         (ctl_q),
        .bus_rst       (eng_bus_reset)
    );

    for (genvar gi = 0; gi < N_TIME; gi++) begin : g_time
        localparam logic [ADDR_W-1:0] MY_ADR = (gi == 0) ? ADR_SCLH : ADR_SCLL;

        // Write decode for this timing register.
        always_comb time_we[gi] = host_wr && (host_addr == MY_ADR);

        i2c_scl_time_reg #(
            .WIDTH   (TIME_W),
            .RST_VAL (TIME_W'(TIME_RST))
        ) u_time (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (time_we[gi]),
            .wdata (host_wdata[TIME_W-1:0]),
            .q     (time_q[gi])
        );
    end

    i2c_rd_mux #(
        .DATA_W (DATA_W),
        .TIME_W (TIME_W)
    ) u_rd (
        .addr   (host_addr),
        .ctl    (ctl_q),
        .scl_hi (time_q[0]),
        .scl_lo (time_q[1]),
        .rdata  (host_rdata)
    );

    // Control outputs to the protocol engine.
    always_comb begin
        ctl_enable   = ctl_q[BIT_EN];
        ctl_start    = ctl_q[BIT_STA];
        ctl_stop     = ctl_q[BIT_STO];
        ctl_irq      = ctl_q[BIT_IRQ];
        ctl_ack      = ctl_q[BIT_ACK];
        scl_high_cnt = time_q[0];
        scl_low_cnt  = time_q[1];
    end

    AST_RD_WO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADR_SET || host_addr == ADR_CLR) |-> host_rdata == '0); // R4
endmodule

// File: tb/i2c_ctrl_regs_tb.sv
module i2c_ctrl_regs_tb;
    localparam int DW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [2:0]    host_addr = 3'd0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          eng_evt_irq = 1'b0;
    logic          eng_stop_done = 1'b0;
    logic          ctl_enable, ctl_start, ctl_stop, ctl_irq, ctl_ack;
    logic [TW-1:0] scl_high_cnt, scl_low_cnt;
    logic          eng_bus_reset;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0]    m_ctl;
    logic [TW-1:0] m_hi, m_lo;
    logic          m_brst;

    always #5 clk = ~clk;

    i2c_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_evt_irq(eng_evt_irq), .eng_stop_done(eng_stop_done),
        .ctl_enable(ctl_enable), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
        .ctl_irq(ctl_irq), .ctl_ack(ctl_ack),
        .scl_high_cnt(scl_high_cnt), .scl_low_cnt(scl_low_cnt),
        .eng_bus_reset(eng_bus_reset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return {{(DW-8){1'b0}}, m_ctl};
            3'd3:    return m_hi;
            3'd4:    return m_lo;
            default: return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] a);
        if (a == 3'd0) return "R10";
        if (a == 3'd3 || a == 3'd4) return "R9";
        return "R4";
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] cur, input logic wr,
                                            input logic [2:0] a, input logic [7:0] d,
                                            input logic ei, input logic es);
        logic [7:0] s, c, n;
        s = (wr && a == 3'd1) ? (d & 8'h7C) : 8'h00;  // R2 live bits only
        c = (wr && a == 3'd2) ? (d & 8'h7C) : 8'h00;  // R3
        n = (cur | s) & ~c;
        if (ei) n[3] = 1'b1;                          // R6
        if (es && !s[4]) n[4] = 1'b0;                 // R7
        if (!n[6]) n[4] = 1'b0;                       // R5
        return n;
    endfunction

    task automatic check_outs();
        check("R10", {24'h0, 1'b0, ctl_enable, ctl_start, ctl_stop, ctl_irq, ctl_ack, 2'b00},
              {24'h0, m_ctl});
        check("R9", scl_high_cnt, m_hi);
        check("R9", scl_low_cnt, m_lo);
        check("R8", eng_bus_reset, m_brst);
    endtask

    task automatic step(input logic wr, input logic [2:0] a, input logic [DW-1:0] d,
                        input logic ei, input logic es);
        logic [7:0] n;
        @(negedge clk);
        host_wr = wr; host_addr = a; host_wdata = d;
        eng_evt_irq = ei; eng_stop_done = es;
        #1;
        check(read_tag(a), host_rdata, exp_read(a));
        n = exp_next(m_ctl, wr, a, d[7:0], ei, es);
        @(posedge clk);
        m_brst = m_ctl[6] & ~n[6];
        m_ctl  = n;
        if (wr && a == 3'd3) m_hi = d;
        if (wr && a == 3'd4) m_lo = d;
        #1;
        check_outs();
        @(negedge clk);
        host_wr = 1'b0; eng_evt_irq = 1'b0; eng_stop_done = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1C2C);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        m_ctl = 8'h00; m_hi = 16'd4; m_lo = 16'd4; m_brst = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1", {24'h0, 1'b0, ctl_enable, ctl_start, ctl_stop, ctl_irq, ctl_ack, 2'b00}, 32'h0);
        check("R1", scl_high_cnt, 32'd4);
        check("R1", scl_low_cnt, 32'd4);
        check("R1", eng_bus_reset, 32'd0);
        for (int a = 0; a < 8; a++) step(1'b0, 3'(a), '0, 1'b0, 1'b0);

        // R2 / R4: all-ones set write keeps reserved bits at zero
        step(1'b1, 3'd1, 16'hFFFF, 1'b0, 1'b0);
        check("R2", ctl_enable & ctl_start & ctl_stop & ctl_irq & ctl_ack, 32'd1);
        step(1'b0, 3'd0, '0, 1'b0, 1'b0);
        check("R4", host_rdata, 32'h7C);
        // R4: writes to the read address and unmapped addresses ignored
        step(1'b1, 3'd0, 16'h0000, 1'b0, 1'b0);
        step(1'b1, 3'd6, 16'h0000, 1'b0, 1'b0);
        check("R4", ctl_enable, 32'd1);
        // R3: clear START only
        step(1'b1, 3'd2, 16'h0020, 1'b0, 1'b0);
        check("R3", ctl_start, 32'd0);
        check("R3", ctl_stop, 32'd1);
        // R5 / R8: clearing enable drops STOP and pulses bus reset once
        step(1'b1, 3'd2, 16'h0040, 1'b0, 1'b0);
        check("R5", ctl_stop, 32'd0);
        check("R8", eng_bus_reset, 32'd1);
        step(1'b0, 3'd0, '0, 1'b0, 1'b0);
        check("R8", eng_bus_reset, 32'd0);
        // R5: STOP request without enable is dropped
        step(1'b1, 3'd1, 16'h0010, 1'b0, 1'b0);
        check("R5", ctl_stop, 32'd0);
        // R6: interrupt strobe beats a same-cycle clear
        step(1'b1, 3'd2, 16'h0008, 1'b0, 1'b0);
        step(1'b1, 3'd2, 16'h0008, 1'b1, 1'b0);
        check("R6", ctl_irq, 32'd1);
        // R7: set-port STOP beats a same-cycle stop-done, then stop-done clears
        step(1'b1, 3'd1, 16'h0040, 1'b0, 1'b0);
        step(1'b1, 3'd1, 16'h0010, 1'b0, 1'b1);
        check("R7", ctl_stop, 32'd1);
        step(1'b0, 3'd0, '0, 1'b0, 1'b1);
        check("R7", ctl_stop, 32'd0);
        // R9: full-width timing writes
        step(1'b1, 3'd3, 16'hABCD, 1'b0, 1'b0);
        step(1'b1, 3'd4, 16'h1357, 1'b0, 1'b0);
        check("R9", scl_high_cnt, 32'hABCD);
        check("R9", scl_low_cnt, 32'h1357);

        // Seeded random mix over all addresses and strobes
        for (int i = 0; i < 3000; i++) begin
            logic          rw;
            logic [2:0]    ra;
            logic [DW-1:0] rd;
            rw = ($urandom % 3) != 0;
            ra = 3'($urandom % 8);
            rd = DW'($urandom);
            step(rw, ra, rd, ($urandom % 8) == 0, ($urandom % 6) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule